// File: doc/BRIEF.md
# Two-Port RAM with Address Collision Arbitration

This block is a clocked memory with two independent access ports, left and right, sharing one storage array. Each port has an address, a pair of chip-enable pins (one active-low, one active-high), a write strobe that is low for writes, write data, registered read data, and an active-low busy flag. A collision detector watches both ports. When both are selected and present the same address, the port that held that address first keeps full access. The other port sees its busy flag go low, and the block discards any write from it until the flag returns high.

A mode strap sets who makes the arbitration decision. In master mode the block decides and drives the busy flags itself. In slave mode the internal decision is set aside: each port takes an active-low busy input from an external arbiter, and that input alone gates the port's writes. The busy outputs then stay high. Reads are never blocked. A port that reads always receives the word stored at its address.

Top module: `dp_collide_ram`

## Requirements
- R1: A port is selected only when its `*_ce0_n` is 0 and its `*_ce1` is 1. A deselected port never writes the array, never updates its read data and never takes part in a collision.
- R2: In master mode a collision exists only when both ports are selected with equal addresses. Otherwise both `*_busy_n` outputs read 1 one clock later.
- R3: In master mode, when a collision begins because one port's address changes to match a port that was already selected at that address in the previous cycle, the port that changed gets `*_busy_n` = 0 one clock later. The other port's flag stays 1.
- R4: A collision that begins when a chip enable becomes active, while the addresses already match, gives the busy flag to the port that was enabled later.
- R5: A port's busy flag returns to 1 one clock after its addresses stop matching, or one clock after either port is deselected.
- R6: A write (`*_wr_n` = 0) from a port whose busy flag is 0, or from a port that is losing a collision in the clock it begins, leaves the array unchanged.
- R7: A write strobe that is still held after the busy flag has cleared is written into the array on the following clock.
- R8: If both ports start a collision in the same clock, and neither was already selected at that address in the previous cycle, the right port is the one flagged busy.
- R9: In slave mode (`master_mode` = 0) both `*_busy_n` outputs read 1. A port's write is blocked exactly when its `*_busy_in_n` is 0, whatever the addresses are.
- R10: Read data is registered. A selected port with `*_wr_n` = 1 shows the word at its address one clock later. A word written on one port can be read on the other port starting in the cycle after the write.
- R11: A port whose busy flag is 0 still returns the stored word on reads.
- R12: After synchronous reset both `*_busy_n` read 1 and both read-data outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_mode | input | 1 | 1: internal arbitration, 0: external busy inputs |
| l_ce0_n | input | 1 | Left chip enable, active low |
| l_ce1 | input | 1 | Left chip enable, active high |
| l_wr_n | input | 1 | Left strobe, 0 = write, 1 = read |
| l_addr | input | ADDR_W | Left address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data, registered |
| l_busy_in_n | input | 1 | Left external busy, active low (slave mode) |
| l_busy_n | output | 1 | Left busy flag, active low (master mode) |
| r_ce0_n | input | 1 | Right chip enable, active low |
| r_ce1 | input | 1 | Right chip enable, active high |
| r_wr_n | input | 1 | Right strobe, 0 = write, 1 = read |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data, registered |
| r_busy_in_n | input | 1 | Right external busy, active low (slave mode) |
| r_busy_n | output | 1 | Right busy flag, active low (master mode) |

## Verification
The hardest case to reach is a write that is held through a collision and then released. The bench parks one port on an address for a full cycle, then moves the other port onto that address with its write strobe already low. It keeps the strobe low for several cycles and reads the array back through the winner to confirm nothing landed. It then deselects the winner and checks that the flag clears and that the still-held write arrives only afterwards. Who arrived first depends on the previous cycle's state, so each ordering (address arrival, chip-enable arrival, exact tie) starts from both ports deselected.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  // which port currently owns a colliding address
  typedef enum logic [1:0] {
    HOLD_NONE  = 2'd0,
    HOLD_LEFT  = 2'd1,
    HOLD_RIGHT = 2'd2
  } hold_t;

  localparam int SIDES  = 2;
  localparam int SIDE_L = 0;
  localparam int SIDE_R = 1;
endpackage

// File: rtl/dpc_port_gate.sv
module dpc_port_gate #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce0_n,
  input  logic              ce1,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              en,
  output logic              wr_req,
  output logic              rd_req,
  output logic              steady
);
  logic              en_q;
  logic [ADDR_W-1:0] addr_q;

  assign en     = !ce0_n && ce1;
  assign wr_req = en && !wr_n;
  assign rd_req = en && wr_n;
  // selected at the same address in the previous cycle as well
  assign steady = en && en_q && (addr_q == addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q   <= en;
      addr_q <= addr;
    end
  end
endmodule

// File: rtl/dpc_arbiter.sv
module dpc_arbiter #(
  parameter int ADDR_W = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       master_mode,
  input  logic [dpc_pkg::SIDES-1:0]  en,
  input  logic [dpc_pkg::SIDES-1:0]  steady,
  input  logic [ADDR_W-1:0]          addr_l,
  input  logic [ADDR_W-1:0]          addr_r,
  input  logic [dpc_pkg::SIDES-1:0]  busy_ext_n,
  output logic [dpc_pkg::SIDES-1:0]  busy_flag,
  output logic [dpc_pkg::SIDES-1:0]  inhibit
);
  import dpc_pkg::*;

  hold_t            hold_q, hold_nx;
  logic             match;
  logic [SIDES-1:0] lose_nx;

  assign match = en[SIDE_L] && en[SIDE_R] && (addr_l == addr_r);

  always_comb begin
    hold_nx = hold_q;
    if (!match) begin
      hold_nx = HOLD_NONE;
    end else if (hold_q == HOLD_NONE) begin
      // right wins only if it alone was already in place; ties go left
      hold_nx = (steady[SIDE_R] && !steady[SIDE_L]) ? HOLD_RIGHT : HOLD_LEFT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hold_q <= HOLD_NONE;
    else     hold_q <= hold_nx;
  end

  assign busy_flag[SIDE_L] = (hold_q  == HOLD_RIGHT);
  assign busy_flag[SIDE_R] = (hold_q  == HOLD_LEFT);
  assign lose_nx[SIDE_L]   = (hold_nx == HOLD_RIGHT);
  assign lose_nx[SIDE_R]   = (hold_nx == HOLD_LEFT);

  for (genvar s = 0; s < SIDES; s++) begin : g_inh
    assign inhibit[s] = master_mode ? (lose_nx[s] || busy_flag[s]) : !busy_ext_n[s];
  end
endmodule

// File: rtl/dpc_store.sv
module dpc_store #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_l,
  input  logic              re_l,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [DATA_W-1:0] wd_l,
  output logic [DATA_W-1:0] rd_l,
  input  logic              we_r,
  input  logic              re_r,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic [DATA_W-1:0] wd_r,
  output logic [DATA_W-1:0] rd_r
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // same-address double write: the left port, written last, lands
  always_ff @(posedge clk) begin
    if (we_r) mem[addr_r] <= wd_r;
    if (we_l) mem[addr_l] <= wd_l;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_l <= '0;
      rd_r <= '0;
    end else begin
      if (re_l) rd_l <= mem[addr_l];
      if (re_r) rd_r <= mem[addr_r];
    end
  end
endmodule

// File: rtl/dp_collide_ram.sv
module dp_collide_ram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master_mode,
  input  logic              l_ce0_n,
  input  logic              l_ce1,
  input  logic              l_wr_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              l_busy_in_n,
  output logic              l_busy_n,
  input  logic              r_ce0_n,
  input  logic              r_ce1,
  input  logic              r_wr_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  input  logic              r_busy_in_n,
  output logic              r_busy_n
);
  import dpc_pkg::*;

  logic [SIDES-1:0]  ce0_n_v, ce1_v, wr_n_v;
  logic [ADDR_W-1:0] addr_v [SIDES];
  logic [SIDES-1:0]  en_v, wr_v, rd_v, steady_v, busy_v, inh_v, busy_ext_v, we_v;

  assign ce0_n_v    = {r_ce0_n, l_ce0_n};
  assign ce1_v      = {r_ce1, l_ce1};
  assign wr_n_v     = {r_wr_n, l_wr_n};
  assign busy_ext_v = {r_busy_in_n, l_busy_in_n};
  assign addr_v[SIDE_L] = l_addr;
  assign addr_v[SIDE_R] = r_addr;

  for (genvar s = 0; s < SIDES; s++) begin : g_port
    dpc_port_gate #(.ADDR_W(ADDR_W)) u_gate (
      .clk    (clk),
      .rst    (rst),
      .ce0_n  (ce0_n_v[s]),
      .ce1    (ce1_v[s]),
      .wr_n   (wr_n_v[s]),
      .addr   (addr_v[s]),
      .en     (en_v[s]),
      .wr_req (wr_v[s]),
      .rd_req (rd_v[s]),
      .steady (steady_v[s])
    );
    assign we_v[s] = wr_v[s] && !inh_v[s];
  end

  dpc_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk         (clk),
    .rst         (rst),
    .master_mode (master_mode),
    .en          (en_v),
    .steady      (steady_v),
    .addr_l      (l_addr),
    .addr_r      (r_addr),
    .busy_ext_n  (busy_ext_v),
    .busy_flag   (busy_v),
    .inhibit     (inh_v)
  );

  dpc_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk    (clk),
    .rst    (rst),
    .we_l   (we_v[SIDE_L]),
    .re_l   (rd_v[SIDE_L]),
    .addr_l (l_addr),
    .wd_l   (l_wdata),
    .rd_l   (l_rdata),
    .we_r   (we_v[SIDE_R]),
    .re_r   (rd_v[SIDE_R]),
    .addr_r (r_addr),
    .wd_r   (r_wdata),
    .rd_r   (r_rdata)
  );

  // flags are driven only in master mode
  assign l_busy_n = !(master_mode && busy_v[SIDE_L]);
  assign r_busy_n = !(master_mode && busy_v[SIDE_R]);
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              master_mode,
  input logic              l_ce0_n,
  input logic              l_ce1,
  input logic              l_wr_n,
  input logic [ADDR_W-1:0] l_addr,
  input logic [DATA_W-1:0] l_wdata,
  input logic [DATA_W-1:0] l_rdata,
  input logic              l_busy_in_n,
  input logic              l_busy_n,
  input logic              r_ce0_n,
  input logic              r_ce1,
  input logic              r_wr_n,
  input logic [ADDR_W-1:0] r_addr,
  input logic [DATA_W-1:0] r_wdata,
  input logic [DATA_W-1:0] r_rdata,
  input logic              r_busy_in_n,
  input logic              r_busy_n
);
  logic sel_l, sel_r, hit;
  assign sel_l = !l_ce0_n && l_ce1;
  assign sel_r = !r_ce0_n && r_ce1;
  assign hit   = sel_l && sel_r && (l_addr == r_addr);

  // R3: never both flagged
  a_r3_single_loser: assert property (@(posedge clk) disable iff (rst)
    !(!l_busy_n && !r_busy_n));

  // R2: a flag in master mode follows a collision one clock earlier
  a_r2_flag_needs_hit: assert property (@(posedge clk) disable iff (rst)
    (master_mode && $past(master_mode) && (!l_busy_n || !r_busy_n)) |-> $past(hit));

  // R5: no collision in the previous cycle, no flag now
  a_r5_release: assert property (@(posedge clk) disable iff (rst)
    (master_mode && !$past(hit)) |-> (l_busy_n && r_busy_n));

  // R9: slave mode leaves the flags high
  a_r9_slave_quiet: assert property (@(posedge clk) disable iff (rst)
    !master_mode |-> (l_busy_n && r_busy_n));

  // R3: the loser stays flagged while the collision lasts
  a_r3_hold_right: assert property (@(posedge clk) disable iff (rst)
    (master_mode && !r_busy_n && hit) |=> (!r_busy_n || !master_mode));
  a_r3_hold_left: assert property (@(posedge clk) disable iff (rst)
    (master_mode && !l_busy_n && hit) |=> (!l_busy_n || !master_mode));

  // R10: read data moves only on a selected read
  a_r10_left_idle: assert property (@(posedge clk) disable iff (rst)
    !(sel_l && l_wr_n) |=> $stable(l_rdata));
  a_r10_right_idle: assert property (@(posedge clk) disable iff (rst)
    !(sel_r && r_wr_n) |=> $stable(r_rdata));
endmodule

bind dp_collide_ram dpc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_dp_collide_ram.sv
module tb_dp_collide_ram;
  localparam int AW = 6;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic master_mode = 1'b1;
  logic l_ce0_n = 1'b1, l_ce1 = 1'b0, l_wr_n = 1'b1;
  logic r_ce0_n = 1'b1, r_ce1 = 1'b0, r_wr_n = 1'b1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
  logic l_busy_n, r_busy_n;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = !clk;

  dp_collide_ram #(.ADDR_W(AW), .DATA_W(DW)) dut (.*);

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_l(input logic c0n, input logic c1, input logic wn,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    l_ce0_n = c0n; l_ce1 = c1; l_wr_n = wn; l_addr = a; l_wdata = d;
  endtask

  task automatic set_r(input logic c0n, input logic c1, input logic wn,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    r_ce0_n = c0n; r_ce1 = c1; r_wr_n = wn; r_addr = a; r_wdata = d;
  endtask

  task automatic idle();
    set_l(1, 0, 1, '0, '0);
    set_r(1, 0, 1, '0, '0);
  endtask

  task automatic poke_l(input logic [AW-1:0] a, input logic [DW-1:0] d);
    idle();
    set_l(0, 1, 0, a, d);
    tick();
    idle();
  endtask

  task automatic peek_r(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    set_r(0, 1, 1, a, '0);
    tick();
    check(req, r_rdata, exp);
    idle();
  endtask

  task automatic peek_l(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    set_l(0, 1, 1, a, '0);
    tick();
    check(req, l_rdata, exp);
    idle();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(); tick();
    check("R12 left busy", l_busy_n, 1);
    check("R12 right busy", r_busy_n, 1);
    check("R12 left rdata", l_rdata, 0);
    check("R12 right rdata", r_rdata, 0);
    rst = 1'b0;
    tick();
  endtask

  task automatic t_select();
    poke_l(5, 16'h1234);
    // ce0_n high: deselected
    set_l(1, 1, 0, 5, 16'hBAD0);
    tick();
    // ce1 low: deselected
    set_l(0, 0, 0, 5, 16'hBAD1);
    tick();
    idle();
    peek_r(5, 16'h1234, "R1 deselected write ignored");
    // same address, right deselected by ce1: no collision
    set_l(0, 1, 1, 5, '0);
    set_r(0, 0, 1, 5, '0);
    tick(); tick();
    check("R1 no busy with deselected peer", r_busy_n, 1);
    idle();
  endtask

  task automatic t_cross();
    poke_l(3, 16'h1111);
    peek_r(3, 16'h1111, "R10 left to right");
    idle();
    set_r(0, 1, 0, 4, 16'h2222);
    tick();
    idle();
    peek_l(4, 16'h2222, "R10 right to left");
    set_l(0, 1, 1, 3, '0);
    set_r(0, 1, 1, 4, '0);
    tick(); tick();
    check("R2 distinct addresses left", l_busy_n, 1);
    check("R2 distinct addresses right", r_busy_n, 1);
    idle();
    tick();
  endtask

  task automatic t_addr_collide();
    poke_l(7, 16'h7777);
    set_l(0, 1, 1, 7, '0);
    tick();
    set_r(0, 1, 0, 7, 16'hDEAD);
    tick();
    check("R3 late port flagged", r_busy_n, 0);
    check("R3 early port clear", l_busy_n, 1);
    tick();
    check("R6 blocked write, winner reads", l_rdata, 16'h7777);
    set_r(0, 1, 1, 7, '0);
    tick();
    check("R11 busy port reads", r_rdata, 16'h7777);
    check("R3 flag held", r_busy_n, 0);
    set_r(0, 1, 1, 8, '0);
    tick();
    check("R5 address mismatch clears", r_busy_n, 1);
    idle();
    peek_l(7, 16'h7777, "R6 array unchanged");
  endtask

  task automatic t_held_write();
    poke_l(9, 16'h0000);
    set_l(0, 1, 1, 9, '0);
    tick();
    set_r(0, 1, 0, 9, 16'hC0DE);
    tick();
    check("R3 right flagged", r_busy_n, 0);
    tick();
    check("R6 held write blocked", l_rdata, 16'h0000);
    set_l(0, 0, 1, 9, '0);
    tick();
    check("R5 deselect clears", r_busy_n, 1);
    tick();
    set_r(0, 1, 1, 9, '0);
    tick();
    check("R7 write after release", r_rdata, 16'hC0DE);
    idle();
    tick();
  endtask

  task automatic t_ce_collide();
    idle();
    tick();
    set_r(0, 1, 1, 20, '0);
    set_l(1, 1, 1, 20, '0);
    tick(); tick();
    set_l(0, 1, 1, 20, '0);
    tick();
    check("R4 later enable flagged", l_busy_n, 0);
    check("R4 earlier enable clear", r_busy_n, 1);
    idle();
    tick();
    check("R5 both clear", l_busy_n, 1);
  endtask

  task automatic t_tie();
    idle();
    tick();
    set_l(0, 1, 1, 12, '0);
    set_r(0, 1, 1, 12, '0);
    tick();
    check("R8 tie right flagged", r_busy_n, 0);
    check("R8 tie left clear", l_busy_n, 1);
    idle();
    tick();
  endtask

  task automatic t_slave();
    poke_l(30, 16'hAAAA);
    master_mode = 1'b0;
    set_l(0, 1, 1, 30, '0);
    set_r(0, 1, 1, 30, '0);
    tick(); tick();
    check("R9 slave left flag high", l_busy_n, 1);
    check("R9 slave right flag high", r_busy_n, 1);
    r_busy_in_n = 1'b0;
    set_r(0, 1, 0, 30, 16'hBBBB);
    tick();
    set_r(0, 1, 1, 30, '0);
    tick();
    check("R9 external busy blocks", r_rdata, 16'hAAAA);
    r_busy_in_n = 1'b1;
    set_r(0, 1, 0, 30, 16'hBBBB);
    tick();
    set_r(0, 1, 1, 30, '0);
    tick();
    check("R9 internal decision ignored", l_rdata, 16'hBBBB);
    idle();
    l_busy_in_n = 1'b0;
    set_l(0, 1, 0, 31, 16'hCCCC);
    tick();
    l_busy_in_n = 1'b1;
    idle();
    peek_r(31, 16'h0000, "R9 blocked without collision");
    master_mode = 1'b1;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #3;
    t_reset();
    poke_l(31, 16'h0000);
    t_select();
    t_cross();
    t_addr_collide();
    t_held_write();
    t_ce_collide();
    t_tie();
    t_slave();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule